// File: doc/BRIEF.md
# Periodic Tick Interrupt Controller

This block turns a slow tick strobe into three periodic interrupt sources. An 8-bit binary divider advances once per one-cycle tick strobe (nominally 256 Hz). Three of its bits act as square-wave taps at 32 Hz, 8 Hz and 2 Hz. Each tap has an event flag that latches on the tap's falling edge and an enable bit. One interrupt request line goes to the processor and is high while any enabled flag is set.

Software reaches the block through a small register port. The port has an address, a 4-bit write nibble, a write strobe and a read strobe, and read data is returned combinationally in the same cycle. Reading the event-flag register returns the flags and clears them. A write-only control bit restarts the divider from zero without disturbing flags or enables. The register decode has four selections: `SEL_NONE`, `SEL_MASK`, `SEL_FLAG` and `SEL_CTRL`. The divider has no sequencing states. It counts, or it clears on a restart, and a restart wins over a tick in the same cycle.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After reset the enable bits, the event flags, the divider count and the interrupt output are all 0.
- R2: The divider count advances by one on every cycle in which `tick_stb` is 1 and wraps from 255 to 0. Count bits 2, 4 and 6 are the 32 Hz, 8 Hz and 2 Hz taps.
- R3: An event flag is set in the cycle after its tap falls from 1 to 0, whether its enable bit is 0 or 1. Flag bit 0 belongs to 32 Hz, bit 1 to 8 Hz and bit 2 to 2 Hz.
- R4: A read of address 0xEF returns the flags in data bits 2:0 and clears all flags at the next edge. A write to 0xEF changes nothing.
- R5: If a tap falls in the same cycle as a read of 0xEF, the read returns the flags as they were before that cycle, and the new event's flag is 1 afterwards.
- R6: A write to address 0xEB loads the enable bits from data bits 2:0 (bit 1 enables, bit 0 masks). A read of 0xEB returns them.
- R7: `irq` is 1 exactly when some flag and its enable bit are both 1.
- R8: A write to address 0xF9 with data bit 2 set clears the divider and its edge history, so no flag is set by the restart itself. Counting resumes on the next tick, and flags and enable bits are kept.
- R9: A write to 0xF9 with data bit 2 clear has no effect. A read of 0xF9, of an unmapped address, or of data bit 3 returns 0, and `bus_rdata` is 0 when `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_stb | input | 1 | One-cycle divider advance strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 4 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is a clearing read that lands in the exact cycle in which a tap's falling edge is being captured. The bench gets there by counting ticks to a known count value. It issues the read one cycle after the tick that takes the count across a multiple of eight. The read must return 0 while the flag and `irq` appear one cycle later. A restart is issued while taps are high to expose any false edge. A long run with all enables set and scattered reads is compared against a behavioural model on every clock.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 4;
    localparam int CNT_W   = 8;
    localparam int NSRC    = 3;
    localparam int TAP_LO  = 2;
    localparam int TAP_GAP = 2;

    localparam logic [ADDR_W-1:0] ADR_MASK = 8'hEB;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 8'hEF;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 8'hF9;
    localparam int                CTRL_RESTART_BIT = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    function automatic int tap_bit(input int idx);
        return TAP_LO + TAP_GAP * idx;
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int CNT_W = tick_irq_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_stb,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    always_comb begin
        count_d = count_q;
        if (restart) begin
            count_d = '0;
        end else if (tick_stb) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/tap_fall_detect.sv
module tap_fall_detect #(
    parameter int CNT_W = tick_irq_pkg::CNT_W,
    parameter int NSRC  = tick_irq_pkg::NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             restart,
    output logic [NSRC-1:0]  fall
);
    logic [NSRC-1:0] tap_now;
    logic [NSRC-1:0] tap_prev;

    for (genvar i = 0; i < NSRC; i++) begin : g_tap
        localparam int BITPOS = tick_irq_pkg::tap_bit(i);
        assign tap_now[i] = count[BITPOS];
        assign fall[i]    = tap_prev[i] & ~tap_now[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_prev <= '0;
        end else if (restart) begin
            tap_prev <= '0;
        end else begin
            tap_prev <= tap_now;
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC = tick_irq_pkg::NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] fall,
    input  logic            flag_rd,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_wdata,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] mask,
    output logic            irq
);
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] pend;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (fall[i]) begin
                flag_q[i] <= 1'b1;
            end else if (flag_rd) begin
                flag_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else if (mask_we) begin
                mask_q[i] <= mask_wdata[i];
            end
        end

        assign pend[i] = flag_q[i] & mask_q[i];
    end

    assign flags = flag_q;
    assign mask  = mask_q;
    assign irq   = |pend;
endmodule

// File: rtl/tick_regif.sv
module tick_regif
    import tick_irq_pkg::*;
#(
    parameter int NSRC = tick_irq_pkg::NSRC
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NSRC-1:0]   flags,
    input  logic [NSRC-1:0]   mask,
    output logic              restart,
    output logic              mask_we,
    output logic              flag_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    reg_sel_e sel;

    always_comb begin
        unique case (bus_addr)
            ADR_MASK: sel = SEL_MASK;
            ADR_FLAG: sel = SEL_FLAG;
            ADR_CTRL: sel = SEL_CTRL;
            default:  sel = SEL_NONE;
        endcase
    end

    always_comb begin
        restart   = 1'b0;
        mask_we   = 1'b0;
        flag_rd   = 1'b0;
        bus_rdata = '0;
        unique case (sel)
            SEL_MASK: begin
                mask_we = bus_wr;
                if (bus_rd) bus_rdata[NSRC-1:0] = mask;
            end
            SEL_FLAG: begin
                flag_rd = bus_rd;
                if (bus_rd) bus_rdata[NSRC-1:0] = flags;
            end
            SEL_CTRL: begin
                restart = bus_wr & bus_wdata[CTRL_RESTART_BIT];
            end
            SEL_NONE: begin
                restart = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
    import tick_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_stb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] count;
    logic [NSRC-1:0]  fall;
    logic [NSRC-1:0]  flags;
    logic [NSRC-1:0]  mask;
    logic             restart;
    logic             mask_we;
    logic             flag_rd;

    tick_divider #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_stb (tick_stb),
        .restart  (restart),
        .count    (count)
    );

    tap_fall_detect #(.CNT_W(CNT_W), .NSRC(NSRC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .restart (restart),
        .fall    (fall)
    );

    irq_flag_bank #(.NSRC(NSRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .flag_rd    (flag_rd),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata[NSRC-1:0]),
        .flags      (flags),
        .mask       (mask),
        .irq        (irq)
    );

    tick_regif #(.NSRC(NSRC)) u_regs (
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .flags     (flags),
        .mask      (mask),
        .restart   (restart),
        .mask_we   (mask_we),
        .flag_rd   (flag_rd),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk
    import tick_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_stb,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [NSRC-1:0]   fall,
    input logic [NSRC-1:0]   flags,
    input logic [NSRC-1:0]   mask
);
    logic rd_flag_c;
    logic restart_c;
    assign rd_flag_c = bus_rd && (bus_addr == ADR_FLAG);
    assign restart_c = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[CTRL_RESTART_BIT];

    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_stb && !restart_c) |=> (count == $past(count) + 1'b1)); // R2

    AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |=> ((flags & $past(fall)) == $past(fall))); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_flag_c |=> ((flags & $past(flags)) == $past(flags))); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag_c && fall == '0) |=> (flags == '0)); // R4

    AST_EDGE_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag_c && fall != '0) |=> (flags == $past(fall))); // R5

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_MASK) |=> (mask == $past(bus_wdata[NSRC-1:0]))); // R6

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0 && flags != '0)); // R7

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart_c |=> (count == '0 && fall == '0)); // R8

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_addr == ADR_CTRL) |-> (bus_rdata == '0)); // R9

    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1] == 1'b0); // R9
endmodule

bind tick_irq_ctrl tick_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_stb  (tick_stb),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (count),
    .fall      (fall),
    .flags     (flags),
    .mask      (mask)
);

// File: tb/sim_tick_irq_ctrl.sv
module sim_tick_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_stb = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [3:0] bus_wdata = 4'h0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int got_rd;
    int got_irq;

    // behavioural reference state
    int m_cnt = 0, m_prev = 0, m_flags = 0, m_mask = 0;

    always #4 clk = ~clk;

    tick_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_stb(tick_stb),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int taps_of(input int c);
        return (((c >> 2) & 1) << 0) | (((c >> 4) & 1) << 1) | (((c >> 6) & 1) << 2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_prev = 0; m_flags = 0; m_mask = 0;
        end else begin
            int t, f;
            bit rs;
            t  = taps_of(m_cnt);
            f  = m_prev & ~t & 7;
            rs = bus_wr && bus_addr == 8'hF9 && bus_wdata[2];
            m_flags = ((bus_rd && bus_addr == 8'hEF) ? 0 : m_flags) | f;
            if (bus_wr && bus_addr == 8'hEB) m_mask = int'(bus_wdata) & 7;
            m_prev = rs ? 0 : t;
            m_cnt  = rs ? 0 : (tick_stb ? (m_cnt + 1) % 256 : m_cnt);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            int exp_rd, exp_irq;
            string tag;
            exp_irq = ((m_flags & m_mask) != 0) ? 1 : 0;
            exp_rd  = 0;
            tag = "R9";
            if (bus_rd && bus_addr == 8'hEB) begin exp_rd = m_mask;  tag = "R6"; end
            if (bus_rd && bus_addr == 8'hEF) begin exp_rd = m_flags; tag = "R4"; end
            check(int'(irq) == exp_irq, "R7", int'(irq), exp_irq);
            check(int'(bus_rdata) == exp_rd, tag, int'(bus_rdata), exp_rd);
        end
    end

    task automatic cyc(input bit tk, input bit wr, input bit rd,
                       input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        tick_stb = tk; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #3;
        got_rd  = int'(bus_rdata);
        got_irq = int'(irq);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, 4'h0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 8'h00, 4'h0);
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(0, 0, 1, a, 4'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] d);
        cyc(0, 1, 0, a, d);
    endtask

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check(got_irq == 0, "R1", got_irq, 0);
        rd(8'hEB); check(got_rd == 0, "R1", got_rd, 0);
        rd(8'hEF); check(got_rd == 0, "R1", got_rd, 0);

        // R3: 32 Hz flag sets with enables at 0; count 0 -> 8
        ticks(8); idle(1);
        rd(8'hEF); check(got_rd == 1, "R3", got_rd, 1);
        check(got_irq == 0, "R7", got_irq, 0);
        rd(8'hEF); check(got_rd == 0, "R4", got_rd, 0);

        // R6: enable load and readback, bit 3 ignored (R9)
        wr(8'hEB, 4'hD);
        rd(8'hEB); check(got_rd == 5, "R6", got_rd, 5);

        // R5: read in the very cycle the edge is captured; count 8 -> 16
        ticks(8);
        rd(8'hEF); check(got_rd == 0, "R5", got_rd, 0);
        idle(1); check(got_irq == 1, "R5", got_irq, 1);
        rd(8'hEF); check(got_rd == 1, "R5", got_rd, 1);
        idle(1); check(got_irq == 0, "R7", got_irq, 0);

        // R4: write to flag register ignored; count 16 -> 24
        ticks(8); idle(1);
        wr(8'hEF, 4'h0);
        rd(8'hEF); check(got_rd == 1, "R4", got_rd, 1);
        check(got_irq == 1, "R7", got_irq, 1);

        // R8: restart while taps high; count 24 -> 28 then restart
        ticks(4);
        wr(8'hF9, 4'h4);
        idle(3);
        rd(8'hEF); check(got_rd == 0, "R8", got_rd, 0);
        rd(8'hEB); check(got_rd == 5, "R8", got_rd, 5);
        ticks(7); idle(2);
        rd(8'hEF); check(got_rd == 0, "R8", got_rd, 0);
        ticks(1); idle(1);
        rd(8'hEF); check(got_rd == 1, "R8", got_rd, 1);

        // R9: write with restart bit clear does nothing; count 8 -> 12 -> 16
        ticks(4);
        wr(8'hF9, 4'hB);
        ticks(4); idle(1);
        rd(8'hEF); check(got_rd == 1, "R9", got_rd, 1);
        rd(8'hF9); check(got_rd == 0, "R9", got_rd, 0);
        rd(8'h00); check(got_rd == 0, "R9", got_rd, 0);
        cyc(0, 0, 0, 8'hEB, 4'h0); check(got_rd == 0, "R9", got_rd, 0);

        // R2: all three taps fall together at count 128
        wr(8'hF9, 4'h4);
        rd(8'hEF);
        ticks(128); idle(1);
        rd(8'hEF); check(got_rd == 7, "R2", got_rd, 7);

        // long run, all enabled, scattered reads, wrap of the divider
        wr(8'hEB, 4'h7);
        for (int i = 0; i < 1200; i++) begin
            if (i % 37 == 5) rd(8'hEF);
            else if (i % 53 == 11) rd(8'hEB);
            else cyc(i % 3 != 0, 0, 0, 8'h00, 4'h0);
        end
        idle(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule